// File: doc/BRIEF.md
# Parallel Printer Port Host Controller

This block is the host-side engine that pushes bytes to a parallel printer. Bytes arrive on a valid/ready stream. Each byte goes onto eight data lines. The block then waits until the printer's busy line reads low, pulses an active-low strobe, and waits for the printer's active-low acknowledge. Only after acknowledge has been seen and released does it take the next byte. The block does not check that the printer received the byte correctly: a transfer is complete when acknowledge arrives.

Software sets three tick counts on plain configuration pins:

- the data setup time before the strobe,
- the strobe width,
- the limit on any wait for the printer.

Busy and acknowledge are asynchronous to the clock, so each passes through a two-stage synchronizer. When a wait runs out, the controller releases the strobe, raises a one-cycle error pulse and returns to idle.

The input stream follows these back-pressure rules:

- A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` stays low for the whole transfer. During that time `in_data` is ignored, and the source must hold or retry its byte.

Top module: `lpt_host_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, `strobe_n` is 1, `err_pulse` is 0 and `pd_out` is 0.
- R2: `in_ready` goes low on the edge that accepts a byte. After a good transfer it rises no earlier than 3 cycles after `ack_n_in` returns high. After a timeout it rises in the same cycle as `err_pulse`.
- R3: `pd_out` shows the accepted byte from the cycle after acceptance and holds it at least until acknowledge is driven. Changes on `in_data` while `in_ready` is low have no effect on it.
- R4: With busy already low, `strobe_n` falls N+1 cycles after the accepting edge, where N is `cfg_setup` and a value of 0 counts as 1.
- R5: `strobe_n` stays low for exactly S cycles, where S is `cfg_strobe` and a value of 0 counts as 1.
- R6: `strobe_n` never falls while the synchronized busy is high. Once `busy_in` drops, the strobe falls 3 cycles after that drop.
- R7: A falling edge of the synchronized acknowledge completes the transfer. This includes a falling edge that occurs while the strobe is still low. An acknowledge that arrives before the strobe is ignored.
- R8: If busy stays high for T cycles after the setup time (T is `cfg_timeout`, with 0 counting as 1), `err_pulse` is high for exactly one cycle, N+T cycles after acceptance. The strobe never falls in this case.
- R9: If acknowledge never arrives, `err_pulse` rises N+S+T+1 cycles after acceptance, with `strobe_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Byte offered by the source |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Controller can accept a byte |
| cfg_setup | input | TICK_W | Data setup ticks before the strobe |
| cfg_strobe | input | TICK_W | Strobe width in ticks |
| cfg_timeout | input | TO_W | Wait limit in ticks |
| pd_out | output | DATA_W | Printer data lines, active high |
| strobe_n | output | 1 | Strobe, active low |
| busy_in | input | 1 | Printer busy, active high, asynchronous |
| ack_n_in | input | 1 | Printer acknowledge, active low, asynchronous |
| err_pulse | output | 1 | One-cycle pulse on a timeout |

## Verification
Two functions can meet in one cycle: the strobe countdown and the capture of an acknowledge edge. A fast printer can pull acknowledge low while the strobe is still being held. The table vectors provoke this with a zero or one cycle printer delay and a strobe width of two and six. In the six-cycle case the acknowledge is also released before the strobe ends. Each such transfer is judged correct only if three things hold: the strobe keeps its full programmed width, the transfer completes without a timeout, and `in_ready` returns inside the window set by the acknowledge release.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WNB   = 3'd2,
    ST_STRB  = 3'd3,
    ST_WACK  = 3'd4,
    ST_WREL  = 3'd5
  } lpt_state_e;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL[g]}};
      else        sh <= {sh[STAGES-2:0], d[g]};
    end
    assign q[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/lpt_tick.sv
module lpt_tick #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= (load_val == '0) ? W'(1) : load_val;
    else if (cnt > W'(1))  cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/lpt_host_ctrl.sv
module lpt_host_ctrl
  import lpt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICK_W = 8,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TICK_W-1:0] cfg_setup,
  input  logic [TICK_W-1:0] cfg_strobe,
  input  logic [TO_W-1:0]   cfg_timeout,
  output logic [DATA_W-1:0] pd_out,
  output logic              strobe_n,
  input  logic              busy_in,
  input  logic              ack_n_in,
  output logic              err_pulse
);
  localparam int TMR_W = (TO_W > TICK_W) ? TO_W : TICK_W;

  lpt_state_e st, nxt;
  logic [1:0] sq;
  logic busy_s, ack_s, ack_d, ack_fall, ack_hit;
  logic tmr_load, tmr_last, err_set;
  logic [TMR_W-1:0] tmr_val;

  // busy resets low, acknowledge resets to its released level
  lpt_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({busy_in, ack_n_in}), .q(sq)
  );
  assign busy_s = sq[1];
  assign ack_s  = sq[0];

  lpt_tick #(.W(TMR_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  assign ack_fall = ack_d & ~ack_s;
  assign in_ready = (st == ST_IDLE);
  assign strobe_n = (st != ST_STRB);

  always_comb begin
    nxt = st; tmr_load = 1'b0; tmr_val = '0; err_set = 1'b0;
    case (st)
      ST_IDLE: if (in_valid) begin
        nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = TMR_W'(cfg_setup);
      end
      ST_SETUP: if (tmr_last) begin
        nxt = ST_WNB; tmr_load = 1'b1; tmr_val = TMR_W'(cfg_timeout);
      end
      ST_WNB: if (!busy_s) begin
        nxt = ST_STRB; tmr_load = 1'b1; tmr_val = TMR_W'(cfg_strobe);
      end else if (tmr_last) begin
        nxt = ST_IDLE; err_set = 1'b1;
      end
      ST_STRB: if (tmr_last) begin
        nxt = ST_WACK; tmr_load = 1'b1; tmr_val = TMR_W'(cfg_timeout);
      end
      ST_WACK: if (ack_hit || ack_fall) begin
        nxt = ST_WREL; tmr_load = 1'b1; tmr_val = TMR_W'(cfg_timeout);
      end else if (tmr_last) begin
        nxt = ST_IDLE; err_set = 1'b1;
      end
      ST_WREL: if (ack_s) begin
        nxt = ST_IDLE;
      end else if (tmr_last) begin
        nxt = ST_IDLE; err_set = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pd_out    <= '0;
      ack_d     <= 1'b1;
      ack_hit   <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      st        <= nxt;
      ack_d     <= ack_s;
      err_pulse <= err_set;
      if (in_valid && in_ready) pd_out <= in_data;
      if (st == ST_IDLE) ack_hit <= 1'b0;
      else if (ack_fall && (st == ST_STRB || st == ST_WACK)) ack_hit <= 1'b1;
    end
  end

  // R6
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WNB && busy_s) |=> strobe_n);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> $stable(pd_out));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (ack_s || err_pulse));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
endmodule

// File: tb/test_lpt_host_ctrl.sv
`timescale 1ns/1ps
module test_lpt_host_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] cfg_setup = 8'd1, cfg_strobe = 8'd1;
  logic [15:0] cfg_timeout = 16'd200;
  logic [7:0] pd_out;
  logic strobe_n, err_pulse;
  logic busy_in = 1'b0, ack_n_in = 1'b1;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  lpt_host_ctrl i_lpt_host_ctrl (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_timeout(cfg_timeout),
    .pd_out(pd_out), .strobe_n(strobe_n), .busy_in(busy_in), .ack_n_in(ack_n_in),
    .err_pulse(err_pulse)
  );

  // columns: byte, setup, strobe width, printer delay, ack length, expected strobe-fall cycle
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{8'hA5, 1, 1, 2,  1, 2},
    '{8'h3C, 4, 3, 5,  2, 5},
    '{8'hFF, 0, 2, 0,  2, 2},
    '{8'h00, 2, 6, 1,  3, 3},
    '{8'h81, 7, 2, 10, 4, 8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int b, input int n, input int s, input int d, input int a,
                          input int hold, input bit noack, input int to,
                          input int exp_fall, input int exp_err);
    logic [7:0] bb;
    int first, width, errk, errcnt, kr, rdy, pc, ac, sw;
    bit hold_bad;
    bb = b[7:0];
    sw = (s == 0) ? 1 : s;
    cfg_setup = n[7:0]; cfg_strobe = s[7:0]; cfg_timeout = to[15:0];
    busy_in = (hold > 0); ack_n_in = 1'b1;
    repeat (4) @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = bb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_data = ~bb;
    first = -1; width = 0; errk = -1; errcnt = 0; kr = -1; rdy = -1; pc = -1; ac = -1;
    hold_bad = 1'b0;
    for (int k = 0; k < 600; k++) begin
      if (!strobe_n) begin
        if (first < 0) first = k;
        width++;
      end
      if (pd_out != bb && kr < 0 && pc >= -1 && ac <= 0) hold_bad = 1'b1;
      if (err_pulse) begin errcnt++; if (errk < 0) errk = k; end
      if (in_ready && rdy < 0) rdy = k;
      if (k == hold) busy_in = 1'b0;
      if (ac > 0) begin
        ac--;
        if (ac == 0) begin ack_n_in = 1'b1; kr = k; end
      end
      if (first == k) begin busy_in = 1'b1; pc = d; end
      if (pc == 0 && !noack) begin ack_n_in = 1'b0; busy_in = 1'b0; ac = a; pc = -2; end
      else if (pc > 0) pc--;
      if (rdy >= 0 && k >= rdy + 2) break;
      @(negedge clk);
    end
    busy_in = 1'b0; ack_n_in = 1'b1;
    if (exp_err < 0) begin
      chk(first == exp_fall, "R4/R6 strobe fall cycle", first, exp_fall);
      chk(width == sw, "R5 strobe width", width, sw);
      chk(!hold_bad, "R3 data held, in_data ignored", hold_bad, 0);
      chk(errcnt == 0, "R7 completes without error", errcnt, 0);
      chk(kr >= 0 && rdy >= kr + 3 && rdy <= kr + 3 + sw + 4, "R2 ready return", rdy, kr + 3);
    end else begin
      chk(errk == exp_err, "R8/R9 error cycle", errk, exp_err);
      chk(errcnt == 1, "R8 single error pulse", errcnt, 1);
      chk(rdy == errk, "R2 ready with error", rdy, errk);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(strobe_n == 1'b1, "R1 strobe_n", strobe_n, 1);
    chk(err_pulse == 1'b0, "R1 err_pulse", err_pulse, 0);
    chk(pd_out == 8'h00, "R1 pd_out", pd_out, 0);

    // R4 R5 R7 vector table, including ack during strobe
    for (int i = 0; i < NV; i++)
      run_xfer(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 0, 1'b0, 200, VEC[i][5], -1);

    // R6 busy held high until cycle 8 after acceptance
    run_xfer(8'h5A, 2, 2, 2, 1, 8, 1'b0, 200, 11, -1);

    // R8 busy never drops
    run_xfer(8'h11, 2, 2, 2, 1, 100000, 1'b0, 5, -1, 7);
    chk(strobe_n == 1'b1, "R8 strobe released", strobe_n, 1);

    // R9 acknowledge never arrives
    run_xfer(8'h22, 1, 2, 0, 1, 0, 1'b1, 6, -1, 10);
    chk(strobe_n == 1'b1, "R9 strobe released", strobe_n, 1);

    // R7 recovery: normal transfer after timeouts
    run_xfer(8'hC3, 3, 1, 3, 2, 0, 1'b0, 200, 4, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule